// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block sits between a set of interrupt-pending lines and the vectoring logic of a processor core. Each source has a programmable level bit (0 = low, 1 = high) and an enable bit. A global enable gates all sources. On every clock cycle the block samples the pending lines and decodes their priority. It then presents one vector request together with the index of the winning source. The winner is chosen first by level and then by the lowest source index.

The core acknowledges a request with a one-cycle vector-taken pulse. The block then records that level as in service. A return-from-interrupt pulse releases the innermost level that is in service. A high-level request may interrupt a low-level routine. Nothing interrupts a high-level routine. After every return, no new vector is issued until the core reports, with an instruction-complete pulse, that one further instruction has finished.

Configuration is written through separate write strobes for the level mask, the enable mask and the global enable. All three registers reset to zero: every source is low level, every source is disabled, and the global enable is off.

Top module: `pic_top`

## Requirements
- R1: After reset `vec_req`, `svc_lo` and `svc_hi` are 0, and every source level bit is low: a source taken without any level write marks `svc_lo`, not `svc_hi`.
- R2: When both high-level and low-level eligible requests are pending, the request is for a high-level source. A source is high level when its bit in the level mask is 1.
- R3: Among eligible requests of the same level, the lowest source index is presented on `vec_idx`.
- R4: A source whose enable bit is 0 never wins arbitration. While the global enable is 0, no request is raised at all.
- R5: While only `svc_lo` is set, an eligible high-level request raises `vec_req`.
- R6: While `svc_hi` is set, no new request of either level is raised.
- R7: While `svc_lo` is set, a low-level request is not raised.
- R8: From the cycle of a `ret_pulse` until the cycle in which `instr_done` pulses, `vec_req` stays low. From the clock edge that ends the `instr_done` cycle, a waiting request may be issued.
- R9: `vec_taken` sets the in-service bit for the level of the presented request. `ret_pulse` clears `svc_hi` if it is set, and otherwise clears `svc_lo`.
- R10: Once `vec_req` is 1, it and `vec_idx` hold their values until `vec_taken` is asserted. This holds even if the pending lines change. `vec_req` falls on the clock edge after the cycle with `vec_taken`.
- R11: Pending lines are decoded every cycle. A request applied in one cycle with the block idle appears on `vec_req` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_we | input | 1 | Write strobe: load `mask_wdata` into the level mask |
| en_we | input | 1 | Write strobe: load `mask_wdata` into the enable mask |
| mask_wdata | input | NUM_SRC | Per-source data for the level or enable mask |
| gen_we | input | 1 | Write strobe for the global enable |
| gen_wdata | input | 1 | Global enable value |
| pend | input | NUM_SRC | Interrupt-pending lines, one per source |
| vec_taken | input | 1 | Core has accepted the presented vector |
| ret_pulse | input | 1 | Return from a service routine |
| instr_done | input | 1 | One instruction after a return has completed |
| vec_req | output | 1 | Vector request |
| vec_idx | output | $clog2(NUM_SRC) | Index of the requesting source |
| svc_lo | output | 1 | A low-level routine is in service |
| svc_hi | output | 1 | A high-level routine is in service |

## Verification
The properties rely on four conditions at the inputs:
- `vec_taken` arrives only while `vec_req` is high.
- `vec_taken` and `ret_pulse` never fall in the same cycle.
- `ret_pulse` occurs only while some level is in service.
- `instr_done` follows a return as a single pulse.

The stimulus drives every handshake from tasks that follow this order. It acknowledges a request only after it has seen `vec_req` high, and it issues a return only after a take. It also leaves the level mask unchanged while a request is outstanding.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prio_we,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               gen_we,
    input  logic               gen_wdata,
    output logic [NUM_SRC-1:0] prio_mask,
    output logic [NUM_SRC-1:0] en_mask,
    output logic               gen
);
    typedef struct packed {
        logic [NUM_SRC-1:0] prio;
        logic [NUM_SRC-1:0] en;
        logic               gen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (prio_we) cfg_d.prio = mask_wdata;
        if (en_we)   cfg_d.en   = mask_wdata;
        if (gen_we)  cfg_d.gen  = gen_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign prio_mask = cfg_q.prio;
    assign en_mask   = cfg_q.en;
    assign gen       = cfg_q.gen;
endmodule

// File: rtl/pic_ffs.sv
module pic_ffs #(
    parameter int NUM_SRC = 8,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               found,
    output logic [IDXW-1:0]    idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/pic_arb.sv
module pic_arb
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] prio_mask,
    input  logic [NUM_SRC-1:0] en_mask,
    input  logic               gen,
    output logic               win_valid,
    output logic [IDXW-1:0]    win_idx,
    output lvl_e               win_lvl
);
    logic [NUM_SRC-1:0] eligible;
    logic [1:0]         lvl_found;
    logic [IDXW-1:0]    lvl_idx [2];

    assign eligible = pend & en_mask & {NUM_SRC{gen}};

    // One first-set finder per level; level 1 searches high sources.
    for (genvar g = 0; g < 2; g++) begin : g_lvl
        logic [NUM_SRC-1:0] lvl_req;
        assign lvl_req = (g == 1) ? (eligible & prio_mask) : (eligible & ~prio_mask);
        pic_ffs #(.NUM_SRC(NUM_SRC)) u_ffs (
            .req   (lvl_req),
            .found (lvl_found[g]),
            .idx   (lvl_idx[g])
        );
    end

    always_comb begin
        win_valid = |lvl_found;
        if (lvl_found[1]) begin
            win_lvl = LVL_HI;
            win_idx = lvl_idx[1];
        end else begin
            win_lvl = LVL_LO;
            win_idx = lvl_idx[0];
        end
    end
endmodule

// File: rtl/pic_svc.sv
module pic_svc
    import pic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  lvl_e take_lvl,
    input  logic ret_pulse,
    input  logic instr_done,
    output logic svc_lo,
    output logic svc_hi,
    output logic block
);
    typedef struct packed {
        logic lo;
        logic hi;
        logic hold;
    } svc_t;

    svc_t svc_d, svc_q;

    always_comb begin
        svc_d = svc_q;
        if (take) begin
            if (take_lvl == LVL_HI) svc_d.hi = 1'b1;
            else                    svc_d.lo = 1'b1;
        end
        if (ret_pulse) begin
            if (svc_q.hi) svc_d.hi = 1'b0;
            else          svc_d.lo = 1'b0;
            svc_d.hold = 1'b1;
        end else if (instr_done) begin
            svc_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_d;
    end

    assign svc_lo = svc_q.lo;
    assign svc_hi = svc_q.hi;
    assign block  = ret_pulse | (svc_q.hold & ~instr_done);
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prio_we,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               gen_we,
    input  logic               gen_wdata,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               vec_taken,
    input  logic               ret_pulse,
    input  logic               instr_done,
    output logic               vec_req,
    output logic [IDXW-1:0]    vec_idx,
    output logic               svc_lo,
    output logic               svc_hi
);
    typedef struct packed {
        logic            req;
        logic [IDXW-1:0] idx;
        lvl_e            lvl;
    } vec_t;

    logic [NUM_SRC-1:0] prio_mask, en_mask;
    logic               gen;
    logic               win_valid;
    logic [IDXW-1:0]    win_idx;
    lvl_e               win_lvl;
    logic               block, admit, take;
    vec_t               vec_d, vec_q;

    pic_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we    (prio_we),
        .en_we      (en_we),
        .mask_wdata (mask_wdata),
        .gen_we     (gen_we),
        .gen_wdata  (gen_wdata),
        .prio_mask  (prio_mask),
        .en_mask    (en_mask),
        .gen        (gen)
    );

    pic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend      (pend),
        .prio_mask (prio_mask),
        .en_mask   (en_mask),
        .gen       (gen),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    assign take = vec_q.req & vec_taken;

    pic_svc u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_lvl   (vec_q.lvl),
        .ret_pulse  (ret_pulse),
        .instr_done (instr_done),
        .svc_lo     (svc_lo),
        .svc_hi     (svc_hi),
        .block      (block)
    );

    // A high winner needs no high routine active; a low winner needs none at all.
    assign admit = (win_lvl == LVL_HI) ? !svc_hi : !(svc_hi || svc_lo);

    always_comb begin
        vec_d = vec_q;
        if (vec_q.req) begin
            if (vec_taken) vec_d.req = 1'b0;
        end else begin
            vec_d.req = win_valid && admit && !block;
            vec_d.idx = win_idx;
            vec_d.lvl = win_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '{req: 1'b0, idx: '0, lvl: LVL_LO};
        else        vec_q <= vec_d;
    end

    assign vec_req = vec_q.req;
    assign vec_idx = vec_q.idx;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int NUM_SRC = 8,
    localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vec_taken,
    input logic            ret_pulse,
    input logic            vec_req,
    input logic [IDXW-1:0] vec_idx,
    input logic            svc_lo,
    input logic            svc_hi
);
    a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_taken) |=> (vec_req && $stable(vec_idx)));

    a_r10_drop_after_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_taken) |=> !vec_req);

    a_r6_no_issue_under_high: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_hi && !vec_req) |=> !vec_req);

    a_r8_return_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ret_pulse |=> !vec_req);

    a_r9_take_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_taken) |=> (svc_lo || svc_hi));

    a_r9_return_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && svc_hi && !vec_taken) |=> (!svc_hi && $stable(svc_lo)));

    a_r9_return_clears_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && !svc_hi && !vec_taken) |=> (!svc_lo && !svc_hi));
endmodule

bind pic_top pic_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_taken (vec_taken),
    .ret_pulse (ret_pulse),
    .vec_req   (vec_req),
    .vec_idx   (vec_idx),
    .svc_lo    (svc_lo),
    .svc_hi    (svc_hi)
);

// File: tb/tb_pic_top.sv
module tb_pic_top;
    localparam int  N      = 4;
    localparam int  IW     = 2;
    localparam time CLK_T  = 10ns;
    localparam int  WD_MAX = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prio_we = 0, en_we = 0, gen_we = 0, gen_wdata = 0;
    logic [N-1:0]  mask_wdata = '0;
    logic [N-1:0]  pend = '0;
    logic          vec_taken = 0, ret_pulse = 0, instr_done = 0;
    logic          vec_req, svc_lo, svc_hi;
    logic [IW-1:0] vec_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_T / 2) clk = ~clk;

    pic_top #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .prio_we(prio_we), .en_we(en_we),
        .mask_wdata(mask_wdata), .gen_we(gen_we), .gen_wdata(gen_wdata),
        .pend(pend), .vec_taken(vec_taken), .ret_pulse(ret_pulse),
        .instr_done(instr_done), .vec_req(vec_req), .vec_idx(vec_idx),
        .svc_lo(svc_lo), .svc_hi(svc_hi)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_prio(logic [N-1:0] v);
        mask_wdata = v; prio_we = 1; step(); prio_we = 0;
    endtask
    task automatic wr_en(logic [N-1:0] v);
        mask_wdata = v; en_we = 1; step(); en_we = 0;
    endtask
    task automatic wr_gen(logic v);
        gen_wdata = v; gen_we = 1; step(); gen_we = 0;
    endtask

    task automatic take();
        vec_taken = 1; step(); vec_taken = 0;
    endtask
    task automatic do_ret();
        ret_pulse = 1; step(); ret_pulse = 0;
    endtask
    task automatic do_done();
        instr_done = 1; step(); instr_done = 0;
    endtask

    // Expected winner: lowest index among high eligible, else lowest low.
    function automatic int exp_idx(logic [N-1:0] elig, logic [N-1:0] pr);
        for (int i = 0; i < N; i++) if (elig[i] && pr[i]) return i;
        for (int i = 0; i < N; i++) if (elig[i]) return i;
        return -1;
    endfunction

    // Clear any outstanding request/service so the block is idle again.
    task automatic drain();
        pend = '0;
        if (vec_req) take();
        while (svc_lo || svc_hi) begin
            do_ret();
            do_done();
        end
        step();
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < WD_MAX) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_MAX);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        step(); step();
        // R1: reset state
        chk("R1 vec_req", vec_req, 0);
        chk("R1 svc_lo", svc_lo, 0);
        chk("R1 svc_hi", svc_hi, 0);
        rst_n = 1; step();
        wr_en('1); wr_gen(1);
        pend = 4'b0100; step();
        chk("R1 req", vec_req, 1);
        chk("R11 idx", vec_idx, 2);
        pend = '0; take();
        chk("R1 svc_lo after default-level take", svc_lo, 1);
        chk("R1 svc_hi after default-level take", svc_hi, 0);
        drain();

        // R2/R3/R11: sweep level mask x pending
        for (int p = 0; p < 16; p++) begin
            wr_prio(4'(p));
            for (int q = 0; q < 16; q++) begin
                int e;
                pend = 4'(q); step();
                e = exp_idx(4'(q), 4'(p));
                chk("R11 req", vec_req, (q != 0));
                if (q != 0) chk("R2 R3 idx", vec_idx, e);
                if (q != 0 && ((q & p) != 0)) begin
                    pend = '0; take();
                    chk("R2 svc_hi", svc_hi, 1);
                end
                drain();
            end
        end

        // R4: enable sweep, global enable on and off
        wr_prio(4'b0110);
        for (int en = 0; en < 16; en++) begin
            wr_en(4'(en));
            for (int q = 0; q < 16; q++) begin
                int e;
                pend = 4'(q); step();
                e = exp_idx(4'(q & en), 4'b0110);
                chk("R4 req", vec_req, ((q & en) != 0));
                if ((q & en) != 0) chk("R4 idx", vec_idx, e);
                drain();
            end
            wr_gen(0);
            pend = '1; step(); step();
            chk("R4 global off", vec_req, 0);
            drain();
            wr_gen(1);
        end
        wr_en('1);

        // R5/R6/R7/R8/R9: nesting
        wr_prio(4'b1000);
        pend = 4'b0010; step();
        chk("R7 setup idx", vec_idx, 1);
        pend = '0; take();
        chk("R9 svc_lo set", svc_lo, 1);
        pend = 4'b0100; step(); step(); step();
        chk("R7 low blocked under low", vec_req, 0);
        pend = 4'b1100; step();
        chk("R5 high preempts low", vec_req, 1);
        chk("R5 idx", vec_idx, 3);
        pend = 4'b0100; take();
        chk("R9 svc_hi set", svc_hi, 1);
        chk("R9 svc_lo kept", svc_lo, 1);
        wr_prio(4'b1010);
        pend = 4'b0111; step(); step(); step();
        chk("R6 nothing under high", vec_req, 0);
        pend = 4'b0010;
        do_ret();
        chk("R9 ret clears high", svc_hi, 0);
        chk("R9 ret keeps low", svc_lo, 1);
        step(); step();
        chk("R8 hold after return", vec_req, 0);
        do_done();
        chk("R8 issue after instr_done", vec_req, 1);
        chk("R8 idx", vec_idx, 1);
        pend = '0; take();
        chk("R9 second high", svc_hi, 1);
        do_ret(); do_done();
        do_ret();
        chk("R9 ret clears low", svc_lo, 0);
        do_done();
        drain();

        // R10: stability before take
        wr_prio('0);
        pend = 4'b0100; step();
        chk("R10 setup", vec_idx, 2);
        pend = 4'b0001; step();
        chk("R10 idx stable", vec_idx, 2);
        pend = '0; step(); step();
        chk("R10 req stable", vec_req, 1);
        chk("R10 idx stable2", vec_idx, 2);
        take();
        chk("R10 drop after take", vec_req, 0);
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule